// File: doc/BRIEF.md
# Serial Control Port with Stereo Output Matrix

This block takes a 24-bit control word from a three-wire serial port made of a shift clock, a data line and a latch strobe. The word carries two 8-bit attenuation codes, a 4-bit routing code, a de-emphasis enable and a flag that applies the left code to both channels. Bits shift into a staging register. The rising edge of the latch line copies the staging register into the active control registers. Those registers drive the block's field outputs, which the attenuator and the de-emphasis filter downstream use. Neither of those is part of this block.

The routing code also drives a stereo output matrix inside the block. Each output channel can be silent, or it can carry the left sample, the right sample, or the average of both. Each choice is made independently. The average is computed one bit wider than the samples and then halved, so it cannot overflow. The three serial wires may be asynchronous to the system clock. They are resynchronized, and their edges are detected in the system clock domain.

Top module: `audio_ctl_router`

## Requirements
- R1: Bits are taken on rising edges of the shift clock, first bit first. Word bit k is the k-th bit shifted. Bits 0..7 form the left attenuation code (bit 0 = LSB). Bits 8..15 form the right code. Bits 16..19 form the routing code, stored so that routing bit i equals word bit 16+i. Bit 20 is the de-emphasis enable and bit 21 is the common-attenuation flag.
- R2: The active fields change only after a rising edge of the latch line. Shifting bits without a latch edge leaves the field outputs and the routed outputs unchanged.
- R3: When more than 24 bits are shifted before a latch edge, only the 24 most recently shifted bits take effect.
- R4: After clear (rst_n low), both attenuation codes read 0xFF, the routing code reads 4'h9, de-emphasis reads 0 and the common flag reads 0.
- R5: The left output is selected by the two-bit code {routing bit 0, routing bit 1}. The codes are 00 = zero, 01 = right sample, 10 = left sample, 11 = average.
- R6: The right output is selected by {routing bit 2, routing bit 3}, using the same code values as R5.
- R7: The average output is floor((L+R)/2), with L and R taken as two's-complement numbers. It is exact over the full sample range, with no wrap.
- R8: Word bits 22 and 23 do not affect any field output.
- R9: A routed output reflects the samples present before the preceding clock edge, which is one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low clear |
| ser_sck_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, sampled at shift-clock rise |
| ser_ltch_i | input | 1 | Latch strobe; rising edge commits the word |
| smp_l_i | input | 16 | Left input sample, two's complement |
| smp_r_i | input | 16 | Right input sample, two's complement |
| out_l_o | output | 16 | Routed left output |
| out_r_o | output | 16 | Routed right output |
| att_l_o | output | 8 | Active left attenuation code |
| att_r_o | output | 8 | Active right attenuation code |
| route_o | output | 4 | Active routing code |
| deemph_o | output | 1 | De-emphasis enable |
| att_common_o | output | 1 | Common-attenuation flag |

## Verification
A serial wire transition reaches the fields three clock edges after it appears at the pin: two synchronizer stages plus the register that acts on the detected edge. The routed outputs follow a sample change after one edge. The bench holds every serial level for four clocks and allows several idle clocks after each latch pulse before it reads the fields. It changes samples on a falling edge and compares the outputs on the next falling edge. The bench sweeps all sixteen routing codes over a set of sample pairs that includes both full-scale extremes and odd sums. It also covers the clear state, a word shifted without a latch, and an over-long word.

// File: rtl/acr_pkg.sv
package acr_pkg;
    localparam int ROUTE_W = 4;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_LEFT  = 2'b10,
        SRC_AVG   = 2'b11
    } src_e;

    localparam logic [ROUTE_W-1:0] ROUTE_CLEAR = 4'h9;
endpackage

// File: rtl/acr_sync.sv
module acr_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/acr_ctl_regs.sv
module acr_ctl_regs
    import acr_pkg::*;
#(
    parameter int ATT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dat_i,
    input  logic               sck_i,
    input  logic               ltch_i,
    output logic [ATT_W-1:0]   att_l_o,
    output logic [ATT_W-1:0]   att_r_o,
    output logic [ROUTE_W-1:0] route_o,
    output logic               deemph_o,
    output logic               common_o
);
    localparam int WORD_W  = 2*ATT_W + ROUTE_W + 4;
    localparam int POS_RT  = 2*ATT_W;
    localparam int POS_DE  = POS_RT + ROUTE_W;
    localparam int POS_CM  = POS_DE + 1;

    typedef struct packed {
        logic [ATT_W-1:0]   att_l;
        logic [ATT_W-1:0]   att_r;
        logic [ROUTE_W-1:0] route;
        logic               de;
        logic               cm;
    } act_t;

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        act_t              act;
        logic              sck_prev;
        logic              ltch_prev;
    } ctl_t;

    ctl_t st_d, st_q;
    logic shift_stb, latch_stb;

    assign shift_stb = sck_i  & ~st_q.sck_prev;
    assign latch_stb = ltch_i & ~st_q.ltch_prev;

    always_comb begin
        st_d = st_q;
        st_d.sck_prev  = sck_i;
        st_d.ltch_prev = ltch_i;
        if (shift_stb) begin
            st_d.sr = {dat_i, st_q.sr[WORD_W-1:1]};
        end
        if (latch_stb) begin
            st_d.act.att_l = st_q.sr[ATT_W-1:0];
            st_d.act.att_r = st_q.sr[2*ATT_W-1:ATT_W];
            st_d.act.route = st_q.sr[POS_RT +: ROUTE_W];
            st_d.act.de    = st_q.sr[POS_DE];
            st_d.act.cm    = st_q.sr[POS_CM];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.act.att_l <= '1;
            st_q.act.att_r <= '1;
            st_q.act.route <= ROUTE_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign att_l_o  = st_q.act.att_l;
    assign att_r_o  = st_q.act.att_r;
    assign route_o  = st_q.act.route;
    assign deemph_o = st_q.act.de;
    assign common_o = st_q.act.cm;

    // Active fields move only on a detected latch edge (R2)
    assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_stb |=> $stable(st_q.act));

    // Staging contents are altered only by shift edges (R3)
    assert_stage_only_shifts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_stb |=> $stable(st_q.sr));

    // Each shift edge enters the sampled bit at the top of the staging word (R1)
    assert_bit_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> st_q.sr[WORD_W-1] == $past(dat_i));
endmodule

// File: rtl/acr_chan_mux.sv
module acr_chan_mux
    import acr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  src_e                code_i,
    input  logic signed [W-1:0] l_i,
    input  logic signed [W-1:0] r_i,
    output logic signed [W-1:0] y_o
);
    localparam int SW = W + 1;

    typedef struct packed {
        logic [W-1:0] y;
    } mux_t;

    mux_t st_d, st_q;
    logic signed [SW-1:0] sum;
    logic signed [W-1:0]  avg;

    always_comb begin
        sum = $signed({l_i[W-1], l_i}) + $signed({r_i[W-1], r_i});
        avg = sum[SW-1:1];
        st_d = st_q;
        unique case (code_i)
            SRC_ZERO:  st_d.y = '0;
            SRC_RIGHT: st_d.y = r_i;
            SRC_LEFT:  st_d.y = l_i;
            SRC_AVG:   st_d.y = avg;
            default:   st_d.y = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_o = $signed(st_q.y);

    // Silent code gives zero on the next edge (R5)
    assert_zero_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        code_i == SRC_ZERO |=> y_o == '0);

    // Pass-through code reproduces the previous sample (R9)
    assert_pass_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_i == SRC_LEFT |=> y_o == $past(l_i));

    // Average lies between the two inputs, so no wrap occurred (R7)
    assert_avg_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_i == SRC_AVG |=>
            ((y_o >= $past(l_i)) || (y_o >= $past(r_i))) &&
            ((y_o <= $past(l_i)) || (y_o <= $past(r_i))));
endmodule

// File: rtl/audio_ctl_router.sv
module audio_ctl_router
    import acr_pkg::*;
#(
    parameter int SMP_W       = 16,
    parameter int ATT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_sck_i,
    input  logic                    ser_dat_i,
    input  logic                    ser_ltch_i,
    input  logic signed [SMP_W-1:0] smp_l_i,
    input  logic signed [SMP_W-1:0] smp_r_i,
    output logic signed [SMP_W-1:0] out_l_o,
    output logic signed [SMP_W-1:0] out_r_o,
    output logic [ATT_W-1:0]        att_l_o,
    output logic [ATT_W-1:0]        att_r_o,
    output logic [ROUTE_W-1:0]      route_o,
    output logic                    deemph_o,
    output logic                    att_common_o
);
    localparam int NCH   = 2;
    localparam int NWIRE = 3;

    logic [NWIRE-1:0]        wire_lvl;
    logic [ROUTE_W-1:0]      route;
    logic signed [SMP_W-1:0] ch_out [NCH];

    acr_sync #(.N(NWIRE), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_ltch_i, ser_sck_i, ser_dat_i}),
        .lvl_o   (wire_lvl)
    );

    acr_ctl_regs #(.ATT_W(ATT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dat_i    (wire_lvl[0]),
        .sck_i    (wire_lvl[1]),
        .ltch_i   (wire_lvl[2]),
        .att_l_o  (att_l_o),
        .att_r_o  (att_r_o),
        .route_o  (route),
        .deemph_o (deemph_o),
        .common_o (att_common_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int B = 2 * g;
        src_e code;
        assign code = src_e'({route[B], route[B+1]});
        acr_chan_mux #(.W(SMP_W)) u_mux (
            .clk    (clk),
            .rst_n  (rst_n),
            .code_i (code),
            .l_i    (smp_l_i),
            .r_i    (smp_r_i),
            .y_o    (ch_out[g])
        );
    end

    assign route_o = route;
    assign out_l_o = ch_out[0];
    assign out_r_o = ch_out[1];

    // Right output silent when its code bits are both low (R6)
    assert_right_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (route[3:2] == 2'b00) |=> out_r_o == '0);
endmodule

// File: tb/audio_ctl_router_tb.sv
module audio_ctl_router_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, dat = 1'b0, ltch = 1'b0;
    logic signed [15:0] sl = '0, sr = '0;
    logic signed [15:0] ol, orr;
    logic [7:0] al, ar;
    logic [3:0] rt;
    logic de, cm;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    audio_ctl_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_sck_i(sck), .ser_dat_i(dat), .ser_ltch_i(ltch),
        .smp_l_i(sl), .smp_r_i(sr),
        .out_l_o(ol), .out_r_o(orr),
        .att_l_o(al), .att_r_o(ar), .route_o(rt),
        .deemph_o(de), .att_common_o(cm)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mkword(input logic [7:0] a_l, input logic [7:0] a_r,
                                           input logic [3:0] rsel, input logic e,
                                           input logic c, input logic [1:0] dc);
        return {dc, c, e, rsel, a_r, a_l};
    endfunction

    function automatic int pick(input int code, input int l, input int r);
        case (code)
            0: return 0;
            1: return r;
            2: return l;
            default: return (l + r) >>> 1;
        endcase
    endfunction

    task automatic shift_bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); dat = v[i]; sck = 1'b0;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic pulse_latch();
        @(negedge clk); ltch = 1'b1;
        repeat (4) @(negedge clk);
        ltch = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_fields(input string req, input logic [23:0] w);
        check({req, " att_l"}, int'(al), int'(w[7:0]));
        check({req, " att_r"}, int'(ar), int'(w[15:8]));
        check({req, " route"}, int'(rt), int'(w[19:16]));
        check({req, " deemph"}, int'(de), int'(w[20]));
        check({req, " common"}, int'(cm), int'(w[21]));
    endtask

    task automatic apply_pair(input int l, input int r);
        @(negedge clk); sl = 16'(l); sr = 16'(r);
        @(negedge clk);
    endtask

    task automatic check_route(input logic [3:0] rsel, input int l, input int r);
        apply_pair(l, r);
        check("R5/R7/R9 left out",  int'(ol),  pick({rsel[0], rsel[1]}, l, r));
        check("R6/R7/R9 right out", int'(orr), pick({rsel[2], rsel[3]}, l, r));
    endtask

    task automatic pat(input int i, output int l, output int r);
        case (i)
            0: begin l = 32767;  r = 32767;  end
            1: begin l = -32768; r = -32768; end
            2: begin l = 32767;  r = -32768; end
            3: begin l = -1;     r = 0;      end
            4: begin l = 1234;   r = -5678;  end
            5: begin l = -3;     r = -4;     end
            default: begin l = 101; r = 6;   end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] w1, w2, w3;
        int l, r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 clear state
        check_fields("R4", mkword(8'hFF, 8'hFF, 4'h9, 1'b0, 1'b0, 2'b00));
        for (int i = 0; i < 7; i++) begin
            pat(i, l, r);
            check_route(4'h9, l, r);
        end

        // R1 R5 R6 R7 R8: sweep every routing code
        for (int s = 0; s < 16; s++) begin
            w1 = mkword(8'(s * 13 + 1), 8'(255 - s * 7), 4'(s), s[0], s[1], 2'(s));
            shift_bits(64'(w1), 24);
            pulse_latch();
            check_fields("R1/R8", w1);
            for (int i = 0; i < 7; i++) begin
                pat(i, l, r);
                check_route(4'(s), l, r);
            end
        end

        // R2: shift without latch leaves everything as it was
        w1 = mkword(8'hA5, 8'h3C, 4'b1010, 1'b1, 1'b0, 2'b11);
        shift_bits(64'(w1), 24);
        pulse_latch();
        w2 = mkword(8'h12, 8'hEF, 4'b0111, 1'b0, 1'b1, 2'b00);
        shift_bits(64'(w2), 24);
        repeat (8) @(negedge clk);
        check_fields("R2 no latch", w1);
        check_route(4'b1010, 500, -900);
        pulse_latch();
        check_fields("R2 latched", w2);
        check_route(4'b0111, 500, -900);

        // R3: over-long word, only final 24 bits count
        w3 = mkword(8'h5A, 8'h81, 4'b1100, 1'b1, 1'b1, 2'b01);
        shift_bits({24'h0, w3, 16'hFFFF}, 40);
        pulse_latch();
        check_fields("R3", w3);
        check_route(4'b1100, -20000, 30000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule